// File: doc/BRIEF.md
# Rotating-Coefficient Dot Product Engine

The engine accepts one unsigned integer sample per cycle and returns, for each accepted sample, the dot product of a pre-added sample against a bank of coefficients. Each tap forms `(x + c) * c`, and the terms of all taps are summed. The coefficients sit in a ring of registers. After every accepted sample the ring moves by one place, so consecutive samples see the bank at successive rotations.

There are two datapath structures, selected by a parameter. In the chain structure the sample walks from tap to tap through one register per tap. The partial sum moves alongside it through a registered adder at each tap. No net fans out to every tap, and one result still leaves per cycle. Each tap delays its own coefficient so that it matches the sample's arrival. A result therefore always uses the bank exactly as it stood when the sample was accepted. The broadcast structure instead sums all taps in a single cycle. Both structures produce identical results and differ only in latency.

The ring is filled serially through a load port. A complete load of N words leaves word k at tap k, which sets the rotation position back to zero.

Top module: `rotdot_top`

## Requirements
- R1: For a sample x accepted while tap j holds coefficient c_j, the result equals the sum over j = 0..N-1 of (x + c_j) * c_j. The arithmetic is unsigned, with no wrap for any input value, including all-ones samples and all-ones coefficients.
- R2: After each accepted sample the ring rotates by one place. Tap j takes the value that tap j+1 held, and tap N-1 takes the value that tap 0 held. Rotation wraps around indefinitely.
- R3: While load_en_i is high, load_data_i enters at tap N-1 each cycle and every other tap takes its upper neighbour's value. After N consecutive load cycles, the k-th word written (counting from 0) sits at tap k.
- R4: A sample offered on valid_i in a cycle with load_en_i high is discarded. It produces no result and causes no rotation.
- R5: With ARCH = ARCH_CHAIN, valid_o rises exactly N+1 cycles after the cycle in which the sample was offered. With ARCH = ARCH_TREE the delay is 1 cycle. Results leave in acceptance order, one per cycle, with no gaps for back-to-back input.
- R6: Reloading or rotating the ring while samples are in flight does not alter the results of samples that have already been accepted.
- R7: Both structures give bit-identical results for identical stimulus.
- R8: After reset, valid_o is low and every coefficient is zero, so a sample accepted before any load yields 0.
- R9: valid_o is asserted once per accepted sample and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_en_i | input | 1 | Shift load_data_i into the coefficient ring this cycle |
| load_data_i | input | COEF_W | Coefficient word to load |
| valid_i | input | 1 | A sample is offered this cycle |
| data_i | input | DATA_W | Sample value |
| valid_o | output | 1 | result_o holds a result this cycle |
| result_o | output | ACC_W | Dot product, ACC_W = max(DATA_W,COEF_W)+1+COEF_W+clog2(N_TAPS) |

## Verification
The hardest case to reach is a coefficient reload that overlaps samples still travelling down the chain. A tap that read the live ring instead of its delayed snapshot would give a wrong answer only in that window. The stimulus sends a back-to-back burst and starts a full reload in the very next cycle. The random phase then interleaves short loads, discarded samples and idle gaps while results are draining. A run of two full bank periods checks that the rotation wraps around.

// File: rtl/rotdot_pkg.sv
package rotdot_pkg;
  typedef enum logic {ARCH_TREE = 1'b0, ARCH_CHAIN = 1'b1} arch_e;
endpackage

// File: rtl/rotdot_ring.sv
module rotdot_ring #(
  parameter int N  = 64,
  parameter int CW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [CW-1:0]        load_data_i,
  input  logic                 rot_i,
  output logic [N-1:0][CW-1:0] coef_o
);
  logic [CW-1:0] cr [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < N; j++) cr[j] <= '0;
    end else if (load_i) begin
      for (int j = 0; j < N; j++) cr[j] <= (j == N-1) ? load_data_i : cr[(j+1)%N];
    end else if (rot_i) begin
      for (int j = 0; j < N; j++) cr[j] <= cr[(j+1)%N];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    assign coef_o[g] = cr[g];
  end

  logic [CW-1:0] ring_xor;
  always_comb begin
    ring_xor = '0;
    for (int j = 0; j < N; j++) ring_xor ^= cr[j];
  end

  // R2
  rot_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rot_i && !load_i) |=> (ring_xor == $past(ring_xor)));
endmodule

// File: rtl/rotdot_tap.sv
module rotdot_tap #(
  parameter int IDX   = 0,
  parameter int DW    = 8,
  parameter int CW    = 8,
  parameter int ACC_W = 23,
  localparam int PA_W   = ((DW > CW) ? DW : CW) + 1,
  localparam int PROD_W = PA_W + CW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             v_i,
  input  logic [DW-1:0]    x_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [CW-1:0]    coef_i,
  output logic             v_o,
  output logic [DW-1:0]    x_o,
  output logic [ACC_W-1:0] acc_o
);
  logic [CW-1:0] c_use;

  // coefficient delayed IDX cycles to meet the sample it belongs to
  if (IDX == 0) begin : g_nodly
    assign c_use = coef_i;
  end else begin : g_dly
    logic [CW-1:0] dl [IDX];
    always_ff @(posedge clk_i) begin
      dl[0] <= coef_i;
      for (int k = 1; k < IDX; k++) dl[k] <= dl[k-1];
    end
    assign c_use = dl[IDX-1];
  end

  logic [PA_W-1:0]   pa;
  logic [PROD_W-1:0] prod;
  assign pa   = PA_W'(x_i) + PA_W'(c_use);
  assign prod = PROD_W'(pa) * PROD_W'(c_use);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o   <= 1'b0;
      x_o   <= '0;
      acc_o <= '0;
    end else begin
      v_o   <= v_i;
      x_o   <= x_i;
      acc_o <= acc_i + ACC_W'(prod);
    end
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_o |-> (acc_o >= $past(acc_i)));
endmodule

// File: rtl/rotdot_chain.sv
module rotdot_chain #(
  parameter int N     = 64,
  parameter int DW    = 8,
  parameter int CW    = 8,
  parameter int ACC_W = 23
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 v_i,
  input  logic [DW-1:0]        x_i,
  input  logic [N-1:0][CW-1:0] coef_i,
  output logic                 lead_v_o,
  output logic                 v_o,
  output logic [ACC_W-1:0]     res_o
);
  logic             v_w   [N+1];
  logic [DW-1:0]    x_w   [N+1];
  logic [ACC_W-1:0] acc_w [N+1];

  assign v_w[0]   = v_i;
  assign x_w[0]   = x_i;
  assign acc_w[0] = '0;

  for (genvar j = 0; j < N; j++) begin : g_tap
    rotdot_tap #(.IDX(j), .DW(DW), .CW(CW), .ACC_W(ACC_W)) u_tap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .v_i    (v_w[j]),
      .x_i    (x_w[j]),
      .acc_i  (acc_w[j]),
      .coef_i (coef_i[j]),
      .v_o    (v_w[j+1]),
      .x_o    (x_w[j+1]),
      .acc_o  (acc_w[j+1])
    );
    if (j > 0) begin : g_step
      // R5
      chain_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        v_w[j+1] |-> $past(v_w[j]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o   <= 1'b0;
      res_o <= '0;
    end else begin
      v_o   <= v_w[N];
      res_o <= acc_w[N];
    end
  end

  assign lead_v_o = v_w[1];
endmodule

// File: rtl/rotdot_tree.sv
module rotdot_tree #(
  parameter int N     = 64,
  parameter int DW    = 8,
  parameter int CW    = 8,
  parameter int ACC_W = 23,
  localparam int PA_W   = ((DW > CW) ? DW : CW) + 1,
  localparam int PROD_W = PA_W + CW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 v_i,
  input  logic [DW-1:0]        x_i,
  input  logic [N-1:0][CW-1:0] coef_i,
  output logic                 lead_v_o,
  output logic                 v_o,
  output logic [ACC_W-1:0]     res_o
);
  logic [ACC_W-1:0] sum;
  always_comb begin
    sum = '0;
    for (int j = 0; j < N; j++) begin
      sum = sum + ACC_W'(PROD_W'(PA_W'(x_i) + PA_W'(coef_i[j])) * PROD_W'(coef_i[j]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o   <= 1'b0;
      res_o <= '0;
    end else begin
      v_o   <= v_i;
      res_o <= sum;
    end
  end

  assign lead_v_o = v_o;
endmodule

// File: rtl/rotdot_top.sv
module rotdot_top
  import rotdot_pkg::*;
#(
  parameter int    N_TAPS = 64,
  parameter int    DATA_W = 8,
  parameter int    COEF_W = 8,
  parameter arch_e ARCH   = ARCH_CHAIN,
  localparam int   PA_W   = ((DATA_W > COEF_W) ? DATA_W : COEF_W) + 1,
  localparam int   ACC_W  = PA_W + COEF_W + $clog2(N_TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic [COEF_W-1:0] load_data_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [ACC_W-1:0]  result_o
);
  localparam int LAT   = (ARCH == ARCH_CHAIN) ? N_TAPS + 1 : 1;
  localparam int CNT_W = $clog2(LAT + 2);

  logic accept;
  logic lead_v;
  logic [N_TAPS-1:0][COEF_W-1:0] coef;

  assign accept = valid_i & ~load_en_i;

  rotdot_ring #(.N(N_TAPS), .CW(COEF_W)) u_ring (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_en_i),
    .load_data_i (load_data_i),
    .rot_i       (accept),
    .coef_o      (coef)
  );

  if (ARCH == ARCH_CHAIN) begin : g_chain
    rotdot_chain #(.N(N_TAPS), .DW(DATA_W), .CW(COEF_W), .ACC_W(ACC_W)) u_eng (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .v_i      (accept),
      .x_i      (data_i),
      .coef_i   (coef),
      .lead_v_o (lead_v),
      .v_o      (valid_o),
      .res_o    (result_o)
    );
  end else begin : g_tree
    rotdot_tree #(.N(N_TAPS), .DW(DATA_W), .CW(COEF_W), .ACC_W(ACC_W)) u_eng (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .v_i      (accept),
      .x_i      (data_i),
      .coef_i   (coef),
      .lead_v_o (lead_v),
      .v_o      (valid_o),
      .res_o    (result_o)
    );
  end

  // samples between acceptance and delivery
  logic [CNT_W-1:0] inflight;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight <= '0;
    else         inflight <= inflight + CNT_W'(accept) - CNT_W'(valid_o);
  end

  // R4
  load_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_en_i && valid_i) |=> !lead_v);

  // R5
  inflight_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight <= CNT_W'(LAT));

  // R9
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (inflight != '0));
endmodule

// File: tb/sim_rotdot_top.sv
module sim_rotdot_top;
  import rotdot_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NT    = 16;
  localparam int DW    = 8;
  localparam int CW    = 8;
  localparam int ACC_W = ((DW > CW) ? DW : CW) + 1 + CW + $clog2(NT);
  localparam int QD    = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_en = 1'b0;
  logic [CW-1:0] load_data = '0;
  logic valid = 1'b0;
  logic [DW-1:0] data = '0;
  logic v0, v1;
  logic [ACC_W-1:0] r0, r1;

  always #(CLK_PERIOD/2) clk = ~clk;

  rotdot_top #(.N_TAPS(NT), .DATA_W(DW), .COEF_W(CW), .ARCH(ARCH_CHAIN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_en_i(load_en), .load_data_i(load_data),
    .valid_i(valid), .data_i(data), .valid_o(v0), .result_o(r0));

  rotdot_top #(.N_TAPS(NT), .DATA_W(DW), .COEF_W(CW), .ARCH(ARCH_TREE)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .load_en_i(load_en), .load_data_i(load_data),
    .valid_i(valid), .data_i(data), .valid_o(v1), .result_o(r1));

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit done = 1'b0;

  longint exp_q [QD];
  int     cyc_q [QD];
  int wr = 0, rd0 = 0, rd1 = 0;
  logic [CW-1:0] mc [NT];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic longint model_dot(input logic [DW-1:0] x);
    longint s = 0;
    for (int j = 0; j < NT; j++) s += (longint'(x) + longint'(mc[j])) * longint'(mc[j]);
    return s;
  endfunction

  // one cycle of stimulus, driven at the falling edge; model follows the requirements
  task automatic step(input bit ld, input logic [CW-1:0] ldd, input bit vl, input logic [DW-1:0] d);
    @(negedge clk);
    load_en = ld; load_data = ldd; valid = vl; data = d;
    if (ld) begin
      // R3: shift in at the top
      for (int j = 0; j < NT-1; j++) mc[j] = mc[j+1];
      mc[NT-1] = ldd;
    end else if (vl) begin
      exp_q[wr % QD] = model_dot(d);
      cyc_q[wr % QD] = cyc;
      wr++;
      // R2: rotate toward tap 0, wrapping
      begin
        logic [CW-1:0] t;
        t = mc[0];
        for (int j = 0; j < NT-1; j++) mc[j] = mc[j+1];
        mc[NT-1] = t;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, '0);
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (v0) begin
        chk(rd0 < wr, "R9 chain", rd0, wr);
        if (rd0 < wr) begin
          chk(r0 == exp_q[rd0 % QD], "R1 chain", r0, exp_q[rd0 % QD]);
          chk(cyc - cyc_q[rd0 % QD] == NT + 1, "R5 chain", cyc - cyc_q[rd0 % QD], NT + 1);
          rd0++;
        end
      end
      if (v1) begin
        chk(rd1 < wr, "R9 tree", rd1, wr);
        if (rd1 < wr) begin
          chk(r1 == exp_q[rd1 % QD], "R7 tree", r1, exp_q[rd1 % QD]);
          chk(cyc - cyc_q[rd1 % QD] == 1, "R5 tree", cyc - cyc_q[rd1 % QD], 1);
          rd1++;
        end
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nfail++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", wr - rd0, 0);
      summary();
    end
  end

  initial begin
    void'($urandom(32'd20517));
    for (int j = 0; j < NT; j++) mc[j] = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(v0 == 1'b0, "R8 chain valid", v0, 0);
    chk(v1 == 1'b0, "R8 tree valid", v1, 0);
    rst_n = 1'b1;
    idle(2);
    chk(v0 == 1'b0 && v1 == 1'b0, "R8 idle", v0, 0);

    // R8: zero coefficients give zero
    step(1'b0, '0, 1'b1, 8'd200);
    idle(NT + 3);

    // R3: directed ramp load, then samples with gaps
    for (int k = 0; k < NT; k++) step(1'b1, CW'(k + 1), 1'b0, '0);
    step(1'b0, '0, 1'b1, 8'd0);
    idle(1);
    step(1'b0, '0, 1'b1, 8'd5);
    idle(3);

    // R2/R5: two full periods back to back, rotation wraps
    for (int k = 0; k < 2 * NT; k++) step(1'b0, '0, 1'b1, DW'($urandom));
    idle(NT + 3);

    // R1: all-ones corner
    for (int k = 0; k < NT; k++) step(1'b1, '1, 1'b0, '0);
    step(1'b0, '0, 1'b1, '1);
    step(1'b0, '0, 1'b1, '0);
    idle(NT + 3);

    // R4: valid offered during loading is dropped
    for (int k = 0; k < NT; k++) step(1'b1, CW'($urandom), 1'b1, DW'($urandom));
    idle(NT + 3);
    chk(rd0 == wr && rd1 == wr, "R4 no result from dropped samples", rd0, wr);
    step(1'b0, '0, 1'b1, 8'd7);
    idle(NT + 3);

    // R6: reload begins while a burst is still in the chain
    for (int k = 0; k < NT; k++) step(1'b0, '0, 1'b1, DW'($urandom));
    for (int k = 0; k < NT; k++) step(1'b1, CW'($urandom), 1'b0, '0);
    step(1'b0, '0, 1'b1, DW'($urandom));
    idle(NT + 3);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit ld = ($urandom % 8) == 0;
      bit vl = ($urandom % 4) != 0;
      step(ld, CW'($urandom), vl, DW'($urandom));
    end
    idle(NT + 4);
    // R9: every accepted sample delivered exactly once
    chk(rd0 == wr, "R9 chain drained", rd0, wr);
    chk(rd1 == wr, "R9 tree drained", rd1, wr);
    done = 1'b1;
    summary();
  end
endmodule